// File: doc/BRIEF.md
# Dual-Source Output-Buffer Flag and Interrupt Combiner

This block sits between the two byte sources of a keyboard-style controller (the keyboard channel and the auxiliary pointing-device channel) and the host-visible side of that controller. Each source raises a level while it has a byte waiting. The block captures the two levels into a two-bit pending field. From that field and the controller's mode byte it produces the output-buffer-full flags (status byte bits 0 and 5, mirrored into output-port bits 4 and 5), the keyboard interrupt (host line 1) and the auxiliary interrupt (host line 12). It also produces a select that tells the data-port read path which source supplies the next byte.

The auxiliary channel counts as the active source only when it is the only one pending. When both sources are pending, the keyboard owns the buffer, the read select and the interrupt. The keyboard interrupt is also suppressed while the keyboard-disable mode bit is set. All outputs are refreshed on each rising clock edge from the levels and the mode byte sampled at that edge. A mode write or a keyboard enable/disable command therefore shows up in the interrupt lines one edge after the mode byte changes.

Top module: `obf_irq_combiner`

## Requirements
- R1: The pending field holds keyboard pending in bit 0 and auxiliary pending in bit 1. Each bit takes the value of its source's level input at every rising clock edge. Every output reflects the inputs sampled at the most recent edge.
- R2: `stat_obf_o` and `oport_obf_o` are 1 when any pending bit is set and 0 when the field is 0.
- R3: `stat_aux_obf_o` and `oport_aux_obf_o` are 1 only when the pending field equals 2 (auxiliary only). They are 0 for the values 0, 1 and 3.
- R4: `irq_aux_o` is 1 exactly when the pending field equals 2 and mode bit 1 (auxiliary interrupt enable) is 1.
- R5: `irq_kbd_o` is 1 exactly when the pending field is 1 or 3, mode bit 0 (keyboard interrupt enable) is 1 and mode bit 4 (keyboard disable) is 0. When both sources are pending, only the keyboard interrupt can be raised.
- R6: `rd_sel_aux_o` is 1 (auxiliary source) only when the pending field equals 2. It is 0 (keyboard source) otherwise, including when both sources are pending.
- R7: The interrupt outputs are registered. A change of the mode byte alone, with the levels held, changes the interrupt lines at the next rising edge.
- R8: While `rst_n` is low, the pending field is cleared and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_lvl_i | input | 1 | Keyboard source has a byte waiting |
| aux_lvl_i | input | 1 | Auxiliary source has a byte waiting |
| mode_i | input | MODE_W (8) | Controller mode byte: bit 0 keyboard interrupt enable, bit 1 auxiliary interrupt enable, bit 4 keyboard disable |
| stat_obf_o | output | 1 | Status bit 0: output buffer full |
| stat_aux_obf_o | output | 1 | Status bit 5: buffer holds an auxiliary byte |
| oport_obf_o | output | 1 | Output-port bit 4 mirror of buffer full |
| oport_aux_obf_o | output | 1 | Output-port bit 5 mirror of auxiliary full |
| irq_kbd_o | output | 1 | Keyboard interrupt, host line 1 |
| irq_aux_o | output | 1 | Auxiliary interrupt, host line 12 |
| rd_sel_aux_o | output | 1 | Data-read source: 1 auxiliary, 0 keyboard |

## Verification
On every cycle, the assertions check the following relations:
- the pending field follows the previous levels;
- the two interrupts are never high together;
- the auxiliary interrupt and the read select never appear without the auxiliary-full flag;
- each interrupt was enabled by the mode bits sampled one edge earlier.

Only the bench's scenarios can show the exact truth tables. These include the keyboard-wins outcome with both sources pending, the keyboard-disable gating, the one-edge response to a mode-only change, and the all-zero state during reset. The bench shows them by comparing every output with its own behavioural model on each clock.

// File: rtl/obfi_pkg.sv
package obfi_pkg;
   localparam int unsigned N_SRC   = 2;
   localparam int unsigned SRC_KBD = 0;
   localparam int unsigned SRC_AUX = 1;

   typedef enum logic [N_SRC-1:0] {
      PEND_NONE = 2'd0,
      PEND_KBD  = 2'd1,
      PEND_AUX  = 2'd2,
      PEND_BOTH = 2'd3
   } pend_e;

   function automatic logic aux_only(input logic [N_SRC-1:0] p);
      return p == PEND_AUX;
   endfunction

   function automatic logic any_pend(input logic [N_SRC-1:0] p);
      return |p;
   endfunction
endpackage

// File: rtl/obfi_pend_reg.sv
module obfi_pend_reg
   import obfi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lvl_i,
   output logic [N_SRC-1:0] pend_o
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_o[g] <= 1'b0;
         else        pend_o[g] <= lvl_i[g];
      end
   end

   // R1: each pending bit follows its level one edge later
   a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend_o == $past(lvl_i));
endmodule

// File: rtl/obfi_flag_decode.sv
module obfi_flag_decode
   import obfi_pkg::*;
(
   input  logic [N_SRC-1:0] pend_i,
   output logic             obf_o,
   output logic             aux_obf_o,
   output logic             sel_aux_o
);
   always_comb begin
      obf_o     = any_pend(pend_i);
      aux_obf_o = aux_only(pend_i);
      sel_aux_o = aux_only(pend_i);
   end
endmodule

// File: rtl/obfi_irq_gen.sv
module obfi_irq_gen
   import obfi_pkg::*;
#(
   parameter int unsigned MODE_W   = 8,
   parameter int unsigned KINT_BIT = 0,
   parameter int unsigned AINT_BIT = 1,
   parameter int unsigned KDIS_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  pend_nxt_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              irq_kbd_o,
   output logic              irq_aux_o
);
   logic kint_en, aint_en, kbd_dis;
   logic kbd_lvl_nxt, aux_lvl_nxt;

   always_comb begin
      kint_en     = mode_i[KINT_BIT];
      aint_en     = mode_i[AINT_BIT];
      kbd_dis     = mode_i[KDIS_BIT];
      aux_lvl_nxt = aux_only(pend_nxt_i) & aint_en;
      kbd_lvl_nxt = any_pend(pend_nxt_i) & ~aux_only(pend_nxt_i)
                    & kint_en & ~kbd_dis;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_kbd_o <= 1'b0;
         irq_aux_o <= 1'b0;
      end else begin
         irq_kbd_o <= kbd_lvl_nxt;
         irq_aux_o <= aux_lvl_nxt;
      end
   end

   // R5: a keyboard interrupt needs enable set and disable clear at the prior edge
   a_r5_kbd_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_kbd_o |-> $past(mode_i[KINT_BIT] && !mode_i[KDIS_BIT]));
   // R4: an auxiliary interrupt needs its enable at the prior edge
   a_r4_aux_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux_o |-> $past(mode_i[AINT_BIT]));
endmodule

// File: rtl/obf_irq_combiner.sv
module obf_irq_combiner
   import obfi_pkg::*;
#(
   parameter int unsigned MODE_W   = 8,
   parameter int unsigned KINT_BIT = 0,
   parameter int unsigned AINT_BIT = 1,
   parameter int unsigned KDIS_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kbd_lvl_i,
   input  logic              aux_lvl_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              stat_obf_o,
   output logic              stat_aux_obf_o,
   output logic              oport_obf_o,
   output logic              oport_aux_obf_o,
   output logic              irq_kbd_o,
   output logic              irq_aux_o,
   output logic              rd_sel_aux_o
);
   localparam int unsigned MAX_BIT = (KINT_BIT > AINT_BIT)
      ? ((KINT_BIT > KDIS_BIT) ? KINT_BIT : KDIS_BIT)
      : ((AINT_BIT > KDIS_BIT) ? AINT_BIT : KDIS_BIT);

   if (MAX_BIT >= MODE_W) begin : g_bad_width
      $error("mode bit position outside mode byte");
   end
   if (KINT_BIT == AINT_BIT || KINT_BIT == KDIS_BIT || AINT_BIT == KDIS_BIT) begin : g_bad_alias
      $error("mode bit positions must be distinct");
   end

   logic [N_SRC-1:0] lvl, pend;
   logic             obf, aux_obf, sel_aux;

   always_comb begin
      lvl          = '0;
      lvl[SRC_KBD] = kbd_lvl_i;
      lvl[SRC_AUX] = aux_lvl_i;
   end

   obfi_pend_reg u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .pend_o (pend)
   );

   obfi_flag_decode u_dec (
      .pend_i    (pend),
      .obf_o     (obf),
      .aux_obf_o (aux_obf),
      .sel_aux_o (sel_aux)
   );

   obfi_irq_gen #(
      .MODE_W   (MODE_W),
      .KINT_BIT (KINT_BIT),
      .AINT_BIT (AINT_BIT),
      .KDIS_BIT (KDIS_BIT)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_nxt_i (lvl),
      .mode_i     (mode_i),
      .irq_kbd_o  (irq_kbd_o),
      .irq_aux_o  (irq_aux_o)
   );

   always_comb begin
      stat_obf_o      = obf;
      oport_obf_o     = obf;
      stat_aux_obf_o  = aux_obf;
      oport_aux_obf_o = aux_obf;
      rd_sel_aux_o    = sel_aux;
   end

   // R5: the two interrupt lines are never raised together
   a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_kbd_o && irq_aux_o));
   // R4: the auxiliary interrupt only accompanies the auxiliary-full flag
   a_r4_aux_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_aux_o |-> (stat_aux_obf_o && stat_obf_o));
   // R6: the auxiliary read select implies the auxiliary-full flag
   a_r6_sel_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel_aux_o |-> stat_aux_obf_o);
   // R3: an auxiliary-full flag is always also a buffer-full flag
   a_r3_aux_in_obf: assert property (@(posedge clk) disable iff (!rst_n)
      stat_aux_obf_o |-> stat_obf_o);
endmodule

// File: tb/obf_irq_combiner_tb.sv
module obf_irq_combiner_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       kbd = 1'b0, aux = 1'b0;
   logic [7:0] mode = 8'h03;
   logic       s_obf, s_aux, p_obf, p_aux, i_kbd, i_aux, sel;

   int checks = 0;
   int errors = 0;

   // model state
   bit m_kp = 0, m_ap = 0, m_ik = 0, m_ia = 0;

   always #10 clk = ~clk;

   obf_irq_combiner u_dut (
      .clk(clk), .rst_n(rst_n), .kbd_lvl_i(kbd), .aux_lvl_i(aux), .mode_i(mode),
      .stat_obf_o(s_obf), .stat_aux_obf_o(s_aux), .oport_obf_o(p_obf),
      .oport_aux_obf_o(p_aux), .irq_kbd_o(i_kbd), .irq_aux_o(i_aux),
      .rd_sel_aux_o(sel)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_kp <= 0; m_ap <= 0; m_ik <= 0; m_ia <= 0;
      end else begin
         m_kp <= kbd;
         m_ap <= aux;
         m_ia <= aux && !kbd && mode[1];
         m_ik <= kbd && mode[0] && !mode[4];
      end
   end

   task automatic chk(input string req, input logic act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%b exp=%b t=%0t kbd=%b aux=%b mode=%h",
                  req, act, exp, $time, m_kp, m_ap, mode);
      end
   endtask

   task automatic compare_all();
      bit any_p, aonly;
      any_p = m_kp || m_ap;
      aonly = m_ap && !m_kp;
      chk("R2 stat_obf", s_obf, any_p);
      chk("R2 oport_obf", p_obf, any_p);
      chk("R3 stat_aux_obf", s_aux, aonly);
      chk("R3 oport_aux_obf", p_aux, aonly);
      chk("R6 rd_sel_aux", sel, aonly);
      chk("R4 irq_aux", i_aux, m_ia);
      chk("R5 irq_kbd", i_kbd, m_ik);
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) if (rst_n) compare_all();

   task automatic step(input bit k, input bit a, input logic [7:0] m);
      @(negedge clk);
      #1;
      kbd = k; aux = a; mode = m;
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      kbd = 1'b1; aux = 1'b1; mode = 8'hFF;
      #5;
      // R8: outputs low while reset held, even with both levels up
      chk("R8 stat_obf", s_obf, 0); chk("R8 stat_aux", s_aux, 0);
      chk("R8 oport_obf", p_obf, 0); chk("R8 oport_aux", p_aux, 0);
      chk("R8 irq_kbd", i_kbd, 0); chk("R8 irq_aux", i_aux, 0);
      chk("R8 sel", sel, 0);
      repeat (3) @(negedge clk);
      chk("R8 irq_kbd held", i_kbd, 0);
      chk("R8 stat_obf held", s_obf, 0);
      kbd = 0; aux = 0; mode = 8'h03;
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R3 R6: each pending combination with both interrupts enabled
      step(0, 0, 8'h03);
      step(1, 0, 8'h03);
      step(0, 1, 8'h03);
      step(1, 1, 8'h03);   // keyboard wins
      step(0, 0, 8'h03);
      // R5: keyboard disable blocks the keyboard interrupt only
      step(1, 0, 8'h13);
      step(1, 1, 8'h13);
      step(0, 1, 8'h13);
      // R4: auxiliary enable clear
      step(0, 1, 8'h01);
      step(1, 0, 8'h01);
      // R7: mode-only change with levels held
      step(1, 0, 8'h00);
      step(1, 0, 8'h01);
      step(1, 0, 8'h11);
      step(1, 0, 8'h01);
      step(0, 1, 8'h00);
      step(0, 1, 8'h02);
      step(0, 1, 8'h00);
      @(negedge clk);
      // R7: a directed check on the edge after a mode change
      #2;
      chk("R7 irq_aux after mode clear", i_aux, 0);
      step(0, 1, 8'h02);
      @(negedge clk); #2;
      chk("R7 irq_aux after mode set", i_aux, 1);
      // R1: random level and mode sequences
      for (int i = 0; i < 400; i++)
         step(1'($urandom), 1'($urandom), 8'($urandom));
      // R8: mid-run reset clears everything
      step(1, 1, 8'h01);
      @(negedge clk); #2;
      rst_n = 1'b0;
      #1;
      chk("R8 obf after reset", s_obf, 0);
      chk("R8 irq_kbd after reset", i_kbd, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      repeat (3) step(1, 0, 8'h01);
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule